// File: doc/BRIEF.md
# Neighbour Vector Exchange and Blend

This block sits in one cell of a two-dimensional array of probability-vector search engines. On a start pulse it takes a snapshot of the cell's local probability vector and confidence value. It broadcasts the snapshot to its four adjacent cells over per-link valid/ready channels, one 8-bit packet per vector entry and then one packet for the confidence value. At the same time it collects the same kind of stream from each neighbour.

Once every link has delivered a full stream, the block picks the neighbour that reports the highest confidence. It then blends that neighbour's vector into the local one. The blend weight is 2^-k, where k is the position of the most significant set bit of the winning confidence. So the recombination needs only right shifts and one 8-bit add per entry. The blended vector is presented on a parallel output, and a one-cycle done pulse marks it.

Top module: `nbr_blend`

## Requirements
- R1: After a start, the send side emits N+1 packets in this order: entries 0 to N-1 of the local vector (entry e is bits [8e+7:8e] of the vector port), then the local confidence zero-extended to 8 bits. Every packet is offered to all four links. The next packet appears only after every link has accepted the current one, and an offered packet holds stable until it is taken.
- R2: A link that has already taken the current packet sees its valid low until the next packet. All send valids are low outside the sending phase, including after done.
- R3: Each receive link accepts exactly N+1 packets per round: entries 0 to N-1, then a confidence packet whose low 5 bits are the confidence. Its ready is low before the round and after its last packet.
- R4: The merge selects the neighbour with the strictly highest nonzero confidence. On a tie, the lowest-numbered link wins.
- R5: With k the index of the most significant set bit of the winning confidence, each output entry is (local >> k) + (nbr - (nbr >> k)). A winning confidence of 1 gives k = 0 and returns the local entry.
- R6: The blended entry never exceeds 255, so an all-ones pair blends to 255 with no wrap.
- R7: When every neighbour confidence is zero, the output equals the local snapshot.
- R8: done_o is a single-cycle pulse. vec_o holds its value between pulses. A start_i asserted while a round is in progress is ignored and does not trigger another round.
- R9: Asynchronous reset, at any time, forces all send valids, all receive readies and done_o low, and forces vec_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an exchange round (sampled only when idle) |
| loc_vec_i | input | N*8 | Local probability vector, entry e at [8e+7:8e] |
| loc_conf_i | input | CW | Local confidence value |
| tx_data_o | output | 8 | Packet broadcast to all neighbours |
| tx_valid_o | output | NBR | Per-link packet valid |
| tx_ready_i | input | NBR | Per-link packet ready |
| rx_data_i | input | NBR*8 | Per-link incoming packet |
| rx_valid_i | input | NBR | Per-link incoming valid |
| rx_ready_o | output | NBR | Per-link incoming ready |
| vec_o | output | N*8 | Blended vector |
| done_o | output | 1 | One-cycle pulse when vec_o is updated |

## Verification
A packet handshake completes at the rising edge where valid and ready are both high. The bench therefore sets its readies and valids half a cycle early and records the handshake just before that edge. The blended vector and done_o are registered at the end of the single merge cycle, so both appear one edge after the last receive packet is accepted plus one cycle for the receive-to-merge step. The bench reads them at the falling edge where done_o is first seen high. The pulse and quiet checks then look at the following falling edges. Reset effects are asynchronous and are sampled one time unit after rst_ni falls.

// File: rtl/nbr_blend_pkg.sv
package nbr_blend_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_RECV, ST_MERGE} xchg_state_e;

  // index of the highest set bit, 0 for inputs 0 and 1
  function automatic logic [2:0] msb_pos(input logic [7:0] v);
    logic [2:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) begin
      if (v[i]) p = 3'(i);
    end
    return p;
  endfunction

endpackage

// File: rtl/nbr_tx.sv
module nbr_tx #(
  parameter int N   = 4,
  parameter int NBR = 4,
  parameter int PW  = 8,
  parameter int CW  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [N*PW-1:0]   loc_vec_i,
  input  logic [CW-1:0]     loc_conf_i,
  input  logic [NBR-1:0]    ready_i,
  output logic [PW-1:0]     data_o,
  output logic [NBR-1:0]    valid_o,
  output logic              done_o
);
  localparam int IW = $clog2(N + 1);

  logic [IW-1:0]  idx_q;
  logic [NBR-1:0] taken_q, taken_nxt;
  logic           all_acc;

  assign valid_o   = active_i ? ~taken_q : '0;
  assign taken_nxt = taken_q | (valid_o & ready_i);
  assign all_acc   = &taken_nxt;
  assign done_o    = active_i && all_acc && (idx_q == IW'(N));

  always_comb begin
    data_o = PW'(loc_conf_i);
    for (int i = 0; i < N; i++) begin
      if (idx_q == IW'(i)) data_o = loc_vec_i[i*PW +: PW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      taken_q <= '0;
    end else if (!active_i) begin
      idx_q   <= '0;
      taken_q <= '0;
    end else if (all_acc) begin
      taken_q <= '0;
      idx_q   <= done_o ? '0 : idx_q + 1'b1;
    end else begin
      taken_q <= taken_nxt;
    end
  end

  for (genvar j = 0; j < NBR; j++) begin : g_hold
    assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o[j] && !ready_i[j] |=> valid_o[j] && $stable(data_o));
  end

endmodule

// File: rtl/nbr_rx.sv
module nbr_rx #(
  parameter int N  = 4,
  parameter int PW = 8,
  parameter int CW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            active_i,
  input  logic            valid_i,
  input  logic [PW-1:0]   data_i,
  output logic            ready_o,
  output logic [N*PW-1:0] vec_o,
  output logic [CW-1:0]   conf_o,
  output logic            full_o
);
  localparam int CNTW = $clog2(N + 2);

  logic [CNTW-1:0]         cnt_q;
  logic [N-1:0][PW-1:0]    vec_q;
  logic [CW-1:0]           conf_q;

  assign ready_o = active_i && (cnt_q < CNTW'(N + 1));
  assign full_o  = (cnt_q == CNTW'(N + 1));
  assign vec_o   = vec_q;
  assign conf_o  = conf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      vec_q  <= '0;
      conf_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (ready_o && valid_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNTW'(N)) conf_q <= data_i[CW-1:0];
      for (int i = 0; i < N; i++) begin
        if (cnt_q == CNTW'(i)) vec_q[i] <= data_i;
      end
    end
  end

  assert_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !clear_i |=> full_o && !ready_o);

endmodule

// File: rtl/nbr_merge.sv
module nbr_merge
  import nbr_blend_pkg::*;
#(
  parameter int N   = 4,
  parameter int NBR = 4,
  parameter int PW  = 8,
  parameter int CW  = 5
) (
  input  logic [N*PW-1:0]     loc_vec_i,
  input  logic [NBR*N*PW-1:0] nb_vec_i,
  input  logic [NBR*CW-1:0]   nb_conf_i,
  output logic [N*PW-1:0]     vec_o,
  output logic                any_o
);
  logic [CW-1:0]   best_conf;
  logic [N*PW-1:0] chosen;
  logic [2:0]      k;

  // strict compare: ties keep the lower link, zero never wins
  always_comb begin
    best_conf = '0;
    chosen    = loc_vec_i;
    for (int j = 0; j < NBR; j++) begin
      if (nb_conf_i[j*CW +: CW] > best_conf) begin
        best_conf = nb_conf_i[j*CW +: CW];
        chosen    = nb_vec_i[j*N*PW +: N*PW];
      end
    end
  end

  assign any_o = (best_conf != '0);
  assign k     = msb_pos(8'(best_conf));

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic [PW-1:0] l, x;
    logic [PW:0]   sum;
    assign l = loc_vec_i[e*PW +: PW];
    assign x = chosen[e*PW +: PW];
    always_comb begin
      sum = {1'b0, l >> k} + {1'b0, x - (x >> k)};
      vec_o[e*PW +: PW] = any_o ? sum[PW-1:0] : l;
      assert_no_overflow_R6: assert (!(any_o && sum[PW]));
    end
  end

endmodule

// File: rtl/nbr_blend.sv
module nbr_blend
  import nbr_blend_pkg::*;
#(
  parameter int N   = 4,
  parameter int NBR = 4,
  parameter int PW  = 8,
  parameter int CW  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [N*PW-1:0]     loc_vec_i,
  input  logic [CW-1:0]       loc_conf_i,
  output logic [PW-1:0]       tx_data_o,
  output logic [NBR-1:0]      tx_valid_o,
  input  logic [NBR-1:0]      tx_ready_i,
  input  logic [NBR*PW-1:0]   rx_data_i,
  input  logic [NBR-1:0]      rx_valid_i,
  output logic [NBR-1:0]      rx_ready_o,
  output logic [N*PW-1:0]     vec_o,
  output logic                done_o
);
  xchg_state_e         state_q;
  logic [N*PW-1:0]     loc_vec_q;
  logic [CW-1:0]       loc_conf_q;
  logic                tx_active, rx_active, rx_clear, tx_done;
  logic [NBR-1:0]      rx_full;
  logic [NBR*N*PW-1:0] nb_vec;
  logic [NBR*CW-1:0]   nb_conf;
  logic [N*PW-1:0]     mrg_vec;
  logic                mrg_any;

  assign tx_active = (state_q == ST_SEND);
  assign rx_active = (state_q == ST_SEND) || (state_q == ST_RECV);
  assign rx_clear  = (state_q == ST_IDLE) && start_i;

  nbr_tx #(.N(N), .NBR(NBR), .PW(PW), .CW(CW)) u_tx (
    .clk_i, .rst_ni,
    .active_i  (tx_active),
    .loc_vec_i (loc_vec_q),
    .loc_conf_i(loc_conf_q),
    .ready_i   (tx_ready_i),
    .data_o    (tx_data_o),
    .valid_o   (tx_valid_o),
    .done_o    (tx_done)
  );

  for (genvar j = 0; j < NBR; j++) begin : g_rx
    nbr_rx #(.N(N), .PW(PW), .CW(CW)) u_rx (
      .clk_i, .rst_ni,
      .clear_i (rx_clear),
      .active_i(rx_active),
      .valid_i (rx_valid_i[j]),
      .data_i  (rx_data_i[j*PW +: PW]),
      .ready_o (rx_ready_o[j]),
      .vec_o   (nb_vec[j*N*PW +: N*PW]),
      .conf_o  (nb_conf[j*CW +: CW]),
      .full_o  (rx_full[j])
    );
  end

  nbr_merge #(.N(N), .NBR(NBR), .PW(PW), .CW(CW)) u_merge (
    .loc_vec_i(loc_vec_q),
    .nb_vec_i (nb_vec),
    .nb_conf_i(nb_conf),
    .vec_o    (mrg_vec),
    .any_o    (mrg_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      loc_vec_q  <= '0;
      loc_conf_q <= '0;
      vec_o      <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          loc_vec_q  <= loc_vec_i;
          loc_conf_q <= loc_conf_i;
          state_q    <= ST_SEND;
        end
        ST_SEND:  if (tx_done) state_q <= ST_RECV;
        ST_RECV:  if (&rx_full) state_q <= ST_MERGE;
        ST_MERGE: begin
          vec_o   <= mrg_vec;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_tx_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_SEND |-> tx_valid_o == '0);
  assert_rx_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_MERGE) |-> rx_ready_o == '0);
  assert_keep_local_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_MERGE && !mrg_any |=> vec_o == $past(loc_vec_q));

endmodule

// File: tb/nbr_blend_tb.sv
module nbr_blend_tb;
  localparam int N = 4, NBR = 4, PW = 8, CW = 5, NROWS = 6;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                start_i = 1'b0;
  logic [N*PW-1:0]     loc_vec_i = '0;
  logic [CW-1:0]       loc_conf_i = '0;
  logic [PW-1:0]       tx_data_o;
  logic [NBR-1:0]      tx_valid_o;
  logic [NBR-1:0]      tx_ready_i = '0;
  logic [NBR*PW-1:0]   rx_data_i = '0;
  logic [NBR-1:0]      rx_valid_i = '0;
  logic [NBR-1:0]      rx_ready_o;
  logic [N*PW-1:0]     vec_o;
  logic                done_o;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  nbr_blend #(.N(N), .NBR(NBR), .PW(PW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni, .start_i, .loc_vec_i, .loc_conf_i,
    .tx_data_o, .tx_valid_o, .tx_ready_i,
    .rx_data_i, .rx_valid_i, .rx_ready_o,
    .vec_o, .done_o
  );

  // entries written e3..e0; confidences c3..c0
  localparam logic [31:0] LOC_T [NROWS] = '{32'h00FF4080, 32'h78563412, 32'hFE0155AA,
                                            32'h1000FFFF, 32'hC8640301, 32'h80001008};
  localparam logic [4:0]  LCONF_T [NROWS] = '{5'd5, 5'd0, 5'd31, 5'd16, 5'd1, 5'd8};
  localparam logic [19:0] NCONF_T [NROWS] = '{{5'd1, 5'd7, 5'd7, 5'd3},
                                             {5'd0, 5'd0, 5'd0, 5'd0},
                                             {5'd1, 5'd0, 5'd0, 5'd0},
                                             {5'd30, 5'd16, 5'd0, 5'd31},
                                             {5'd3, 5'd2, 5'd3, 5'd2},
                                             {5'd8, 5'd8, 5'd0, 5'd0}};
  localparam int          SEL_T [NROWS] = '{1, 0, 3, 0, 1, 2};
  localparam logic [31:0] SELV_T [NROWS] = '{32'h1080FF00, 32'hDEADBEEF, 32'h01020304,
                                             32'h20FF00FF, 32'h00320201, 32'h80400008};
  localparam logic [31:0] EXP_T [NROWS] = '{32'h0C9FD020, 32'h78563412, 32'hFE0155AA,
                                            32'h1FF00FFF, 32'h644B0201, 32'h80380208};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nbvec(input int r, input int j);
    return (j == SEL_T[r]) ? SELV_T[r] : (32'hC0C1C2C3 ^ {4{8'(j * 17)}});
  endfunction

  function automatic logic [7:0] rx_pkt(input int r, input int j, input int i);
    logic [31:0] v;
    v = nbvec(r, j);
    if (i < N) return v[i*8 +: 8];
    return {3'b000, NCONF_T[r][j*5 +: 5]};
  endfunction

  function automatic string vtag(input int r);
    if (NCONF_T[r] == '0) return "R7 all-zero keep";
    if (r == 3) return "R6 saturating blend";
    if (r == 2) return "R5 k=0 keeps local";
    return "R4/R5 select and blend";
  endfunction

  task automatic run_round(input int r, input bit poke_start);
    logic [7:0] got [NBR][N+1];
    int  gcnt [NBR];
    int  ridx [NBR];
    bit  racc [NBR];
    bit  tacc [NBR];
    logic [7:0] tdat;
    bit  seen, tx_ok, quiet;
    logic [7:0] bad_act, bad_exp;
    for (int j = 0; j < NBR; j++) begin
      gcnt[j] = 0; ridx[j] = 0; racc[j] = 0; tacc[j] = 0;
    end
    tdat = '0; seen = 0;
    @(negedge clk);
    loc_vec_i = LOC_T[r];
    loc_conf_i = LCONF_T[r];
    start_i = 1'b1;
    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      start_i = poke_start && (cyc == 4);
      for (int j = 0; j < NBR; j++) begin
        if (racc[j]) ridx[j]++;
        if (tacc[j]) begin
          if (gcnt[j] < N + 1) got[j][gcnt[j]] = tdat;
          gcnt[j]++;
        end
      end
      if (done_o) begin
        seen = 1;
        break;
      end
      for (int j = 0; j < NBR; j++) begin
        rx_valid_i[j] = (ridx[j] <= N) && (((cyc + j) % 3) != 2);
        rx_data_i[j*8 +: 8] = (ridx[j] <= N) ? rx_pkt(r, j, ridx[j]) : 8'h00;
        tx_ready_i[j] = ((cyc + j) % 4) != 0;
      end
      #1;
      tdat = tx_data_o;
      for (int j = 0; j < NBR; j++) begin
        racc[j] = rx_valid_i[j] && rx_ready_o[j];
        tacc[j] = tx_valid_o[j] && tx_ready_i[j];
      end
    end
    rx_valid_i = '0;
    tx_ready_i = '0;
    start_i = 1'b0;
    chk(seen, "R8 done seen", 32'(seen), 32'd1);
    tx_ok = 1; bad_act = '0; bad_exp = '0;
    for (int j = 0; j < NBR; j++) begin
      if (gcnt[j] != N + 1) begin
        tx_ok = 0; bad_act = 8'(gcnt[j]); bad_exp = 8'(N + 1);
      end else begin
        for (int i = 0; i <= N; i++) begin
          logic [7:0] e;
          e = (i < N) ? LOC_T[r][i*8 +: 8] : {3'b000, LCONF_T[r]};
          if (got[j][i] !== e) begin
            tx_ok = 0; bad_act = got[j][i]; bad_exp = e;
          end
        end
      end
    end
    chk(tx_ok, "R1 send stream", 32'(bad_act), 32'(bad_exp));
    chk(vec_o === EXP_T[r], vtag(r), vec_o, EXP_T[r]);
    chk(rx_ready_o === '0, "R3 rx ready low after round", 32'(rx_ready_o), 32'd0);
    chk(tx_valid_o === '0, "R2 tx valid low after round", 32'(tx_valid_o), 32'd0);
    @(negedge clk);
    chk(done_o === 1'b0, "R8 done single pulse", 32'(done_o), 32'd0);
    if (poke_start) begin
      quiet = 1;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (tx_valid_o !== '0 || done_o !== 1'b0) quiet = 0;
      end
      chk(quiet, "R8 start during round ignored", 32'(quiet), 32'd1);
    end
  endtask

  initial begin
    #5;
    chk(tx_valid_o === '0, "R9 reset tx valid", 32'(tx_valid_o), 32'd0);
    chk(rx_ready_o === '0, "R9 reset rx ready", 32'(rx_ready_o), 32'd0);
    chk(done_o === 1'b0, "R9 reset done", 32'(done_o), 32'd0);
    chk(vec_o === '0, "R9 reset vec", vec_o, 32'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    for (int r = 0; r < NROWS; r++) run_round(r, 1'b0);

    run_round(0, 1'b1);

    // reset in the middle of a round
    @(negedge clk);
    loc_vec_i = LOC_T[2];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    tx_ready_i = 4'b0101;
    repeat (2) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(tx_valid_o === '0 && rx_ready_o === '0 && done_o === 1'b0, "R9 mid-round reset handshakes",
        {tx_valid_o, rx_ready_o, 3'b0, done_o}, 32'd0);
    chk(vec_o === '0, "R9 mid-round reset vec", vec_o, 32'd0);
    tx_ready_i = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    run_round(5, 1'b0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R8 watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule